// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Interval Requests

This peripheral keeps the time within the current minute for a small minicomputer-style I/O bus. A prescaler divides the system clock down to a 1 kHz tick. Each tick advances a millisecond counter that runs from 0 to 59999 and then starts again at 0.

The counter drives two interval interrupt requests. The short request fires every 32 ms. The long request fires once per minute, on the tick that brings the counter back to 0. Each request is a one-cycle pulse. It carries a 4-bit priority level that software programs through a small configuration write port.

The CPU reads the live count with a one-cycle read strobe. When the device is switched off, the clock stops, no requests leave the block, and every read is answered with an illegal-instruction flag instead of a count. A test-mode input swaps the prescaler ratio for a much shorter one, so that a whole minute can be run through quickly.

Top module: `rtc_ms_clock`

## Requirements
- R1: While rst_ni is low and after its release, the count is 0, both programmed levels are 0, no request is asserted, and a first read returns 0.
- R2: With enable_i high, the count advances by exactly 1 once every DIV system cycles when test_mode_i is 0, and once every TEST_DIV cycles when it is 1. Between ticks the count holds its value.
- R3: The count never leaves 0..59999. The tick that finds 59999 loads 0 and asserts irq_min_o in the following cycle.
- R4: A tick whose new count has its low 5 bits at zero (a multiple of 32) asserts irq_32_o in the following cycle. The wrap to 0 counts as such a tick, so at the wrap both requests are asserted in the same cycle.
- R5: Each request is a one-cycle pulse. Its level output equals the level programmed at the time of the tick, and reads 0 while the request is low. If the programmed level is 0, that request is never asserted.
- R6: A cycle with cfg_we_i high stores cfg_lvl_i as the 32 ms level when cfg_sel_i is 0, and as the one-minute level when cfg_sel_i is 1. The new level applies to ticks after that edge.
- R7: A cycle with rd_i high and the device enabled gives rd_valid_o high in the next cycle. In that cycle rd_data_o holds the count as it stood before any increment at that edge, and rd_illegal_o is 0.
- R8: While enable_i is low, the prescaler is cleared, the count is frozen, and no request is asserted. A read gives rd_valid_o and rd_illegal_o high, with rd_data_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Device enabled |
| test_mode_i | input | 1 | Use the short TEST_DIV prescaler ratio |
| cfg_we_i | input | 1 | Level write strobe |
| cfg_sel_i | input | 1 | 0: 32 ms level, 1: one-minute level |
| cfg_lvl_i | input | 4 | Level value to write |
| rd_i | input | 1 | Read strobe |
| rd_valid_o | output | 1 | Read answer present |
| rd_illegal_o | output | 1 | Read refused, device disabled |
| rd_data_o | output | 16 | Count returned by a read |
| irq_32_o | output | 1 | 32 ms request pulse |
| irq_32_lvl_o | output | 4 | Level of the 32 ms request |
| irq_min_o | output | 1 | One-minute request pulse |
| irq_min_lvl_o | output | 4 | Level of the one-minute request |

## Verification
The bench runs a full minute in test mode and looks at the wrap.

- A design that compares against 60000 one step late would return a count of 60000.
- A design that suppresses the 32 ms request at the wrap would leave the one-minute request unpaired.

Reads are placed on tick edges. A design that returns the count after the increment fails there.

A stretch of disabled operation checks three things: reads are refused, the count is frozen across that stretch, and no request appears. Setting a level of 0 across a multiple of 32 catches a design that still sends the pulse at level 0. Changing the level and then reading it back on the next pulse catches a design that latches the level late.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam int N_CH = 2;
  typedef enum logic {CH_SHORT = 1'b0, CH_MIN = 1'b1} ch_e;
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int DIV      = 50000,
  parameter int TEST_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic test_i,
  output logic tick_o
);
  localparam int MAXD  = (DIV > TEST_DIV) ? DIV : TEST_DIV;
  localparam int PRE_W = $clog2(MAXD + 1);

  logic [PRE_W-1:0] pre_q, lim;

  assign lim    = test_i ? PRE_W'(TEST_DIV - 1) : PRE_W'(DIV - 1);
  // >= so a switch to the short ratio never strands the count above the limit
  assign tick_o = en_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (!en_i || tick_o) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && DIV > 1 && TEST_DIV > 1) |=> !tick_o);
  p_off_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pre_q == '0));
endmodule

// File: rtl/rtc_ms_count.sv
module rtc_ms_count #(
  parameter int CNT_W = 16,
  parameter int WRAP  = 60000,
  parameter int SHORT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             wrap_o
);
  localparam int SH_W = $clog2(SHORT);

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             at_end;

  assign nxt    = cnt_q + 1'b1;
  assign at_end = (cnt_q == CNT_W'(WRAP - 1));
  assign wrap_o = tick_i && at_end;
  // the wrap lands on 0, itself a multiple of SHORT
  assign hit_o  = tick_i && (at_end || (nxt[SH_W-1:0] == '0));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= at_end ? '0 : nxt;
  end

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WRAP));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_end) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rtc_irq_chan.sv
module rtc_irq_chan
  import rtc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  lvl_t cfg_lvl_i,
  input  logic fire_i,
  output lvl_t lvl_cfg_o,
  output logic req_o,
  output lvl_t lvl_o
);
  lvl_t lvl_q, out_lvl_q;
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= '0;
      req_q     <= 1'b0;
      out_lvl_q <= '0;
    end else begin
      if (cfg_we_i) lvl_q <= cfg_lvl_i;
      // level 0 means the request is not sent
      req_q     <= fire_i && (lvl_q != '0);
      out_lvl_q <= fire_i ? lvl_q : '0;
    end
  end

  assign lvl_cfg_o = lvl_q;
  assign req_o     = req_q;
  assign lvl_o     = out_lvl_q;

  p_lvl_tag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (lvl_o != '0));
  p_lvl_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (lvl_o == '0));
  p_cfg_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (lvl_cfg_o == $past(cfg_lvl_i)));
endmodule

// File: rtl/rtc_ms_clock.sv
module rtc_ms_clock
  import rtc_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int TICK_HZ  = 1000,
  parameter int TEST_DIV = 4,
  parameter int CNT_W    = 16,
  parameter int WRAP     = 60000,
  parameter int SHORT    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             test_mode_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [3:0]       cfg_lvl_i,
  input  logic             rd_i,
  output logic             rd_valid_o,
  output logic             rd_illegal_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_32_o,
  output logic [3:0]       irq_32_lvl_o,
  output logic             irq_min_o,
  output logic [3:0]       irq_min_lvl_o
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic             tick, hit, wrap;
  logic [CNT_W-1:0] cnt;
  logic [N_CH-1:0]  fire, req;
  lvl_t             lvl_out [N_CH];
  lvl_t             lvl_cfg [N_CH];

  rtc_prescale #(.DIV(DIV), .TEST_DIV(TEST_DIV)) u_pre (
    .clk_i, .rst_ni, .en_i(enable_i), .test_i(test_mode_i), .tick_o(tick)
  );

  rtc_ms_count #(.CNT_W(CNT_W), .WRAP(WRAP), .SHORT(SHORT)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_o(cnt), .hit_o(hit), .wrap_o(wrap)
  );

  assign fire[CH_SHORT] = hit;
  assign fire[CH_MIN]   = wrap;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    rtc_irq_chan u_ch (
      .clk_i, .rst_ni,
      .cfg_we_i (cfg_we_i && (cfg_sel_i == 1'(g))),
      .cfg_lvl_i(cfg_lvl_i),
      .fire_i   (fire[g]),
      .lvl_cfg_o(lvl_cfg[g]),
      .req_o    (req[g]),
      .lvl_o    (lvl_out[g])
    );
  end

  assign irq_32_o      = req[CH_SHORT];
  assign irq_32_lvl_o  = lvl_out[CH_SHORT];
  assign irq_min_o     = req[CH_MIN];
  assign irq_min_lvl_o = lvl_out[CH_MIN];

  // read captures the pre-increment count at the same edge as the tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_illegal_o <= 1'b0;
      rd_data_o    <= '0;
    end else begin
      rd_valid_o   <= rd_i;
      rd_illegal_o <= rd_i && !enable_i;
      rd_data_o    <= (rd_i && enable_i) ? cnt : '0;
    end
  end

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!irq_32_o && !irq_min_o));
  p_rd_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !enable_i) |=> (rd_valid_o && rd_illegal_o && rd_data_o == '0));
  p_rd_answer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && enable_i) |=> (rd_valid_o && !rd_illegal_o && rd_data_o == $past(cnt)));
  p_min_paired_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_min_o |-> (irq_32_o || $past(lvl_cfg[CH_SHORT]) == '0));
  p_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_min_o |=> !irq_min_o);
endmodule

// File: tb/sim_rtc_ms_clock.sv
module sim_rtc_ms_clock;
  localparam int CLK_PERIOD = 10;
  localparam int DV = 8;
  localparam int TD = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable_i = 1'b0, test_mode_i = 1'b0, cfg_we_i = 1'b0, cfg_sel_i = 1'b0, rd_i = 1'b0;
  logic [3:0] cfg_lvl_i = '0;
  logic rd_valid_o, rd_illegal_o, irq_32_o, irq_min_o;
  logic [15:0] rd_data_o;
  logic [3:0] irq_32_lvl_o, irq_min_lvl_o;

  int checks = 0, errs = 0;
  int m_pre = 0, m_cnt = 0, m_l32 = 0, m_lmin = 0;
  int e32 = 0, emin = 0, el32 = 0, elmin = 0;
  int n32 = 0, nmin = 0, nboth = 0;
  bit started = 0;
  string rd_tag = "";
  logic [16:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_ms_clock #(.CLK_HZ(DV*1000), .TICK_HZ(1000), .TEST_DIV(TD)) u0 (
    .clk_i(clk), .rst_ni, .enable_i, .test_mode_i, .cfg_we_i, .cfg_sel_i, .cfg_lvl_i,
    .rd_i, .rd_valid_o, .rd_illegal_o, .rd_data_o,
    .irq_32_o, .irq_32_lvl_o, .irq_min_o, .irq_min_lvl_o
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference model of the requirements, updated at each edge
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_l32 = 0; m_lmin = 0;
      e32 = 0; emin = 0; el32 = 0; elmin = 0;
    end else begin
      int nxt;
      if (rd_i) begin
        exp_q.push_back(enable_i ? {1'b0, 16'(m_cnt)} : 17'h10000);
        tag_q.push_back(rd_tag);
      end
      e32 = 0; emin = 0; el32 = 0; elmin = 0;
      if (!enable_i) m_pre = 0;
      else if (m_pre >= (test_mode_i ? TD : DV) - 1) begin
        m_pre = 0;
        nxt = m_cnt + 1;
        if (nxt == 60000) begin
          nxt = 0;
          if (m_lmin != 0) begin emin = 1; elmin = m_lmin; end
        end
        if (nxt % 32 == 0 && m_l32 != 0) begin e32 = 1; el32 = m_l32; end
        m_cnt = nxt;
      end else m_pre++;
      if (cfg_we_i) begin
        if (cfg_sel_i) m_lmin = int'(cfg_lvl_i);
        else m_l32 = int'(cfg_lvl_i);
      end
    end
  end

  // monitor: pops read expectations, compares request pulses
  always @(negedge clk) begin
    if (rst_ni && started) begin
      if (rd_valid_o) begin
        if (exp_q.size() == 0) chk(0, "R7", "unexpected read answer", 1, 0);
        else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_illegal_o == e[16], t, "illegal flag", int'(rd_illegal_o), int'(e[16]));
          chk(rd_data_o == e[15:0], t, "read data", int'(rd_data_o), int'(e[15:0]));
        end
      end
      if (irq_32_o || e32 != 0)
        chk(int'(irq_32_o) == e32 && int'(irq_32_lvl_o) == el32,
            enable_i ? "R4 R5" : "R8", "32ms request level", int'(irq_32_lvl_o), el32);
      if (irq_min_o || emin != 0)
        chk(int'(irq_min_o) == emin && int'(irq_min_lvl_o) == elmin,
            enable_i ? "R3 R5" : "R8", "minute request level", int'(irq_min_lvl_o), elmin);
      if (irq_32_o) n32++;
      if (irq_min_o) nmin++;
      if (irq_min_o && irq_32_o) nboth++;
    end
  end

  task automatic do_read(string tag);
    @(negedge clk); rd_i = 1'b1; rd_tag = tag;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic do_cfg(bit sel, int lvl);
    @(negedge clk); cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_lvl_i = 4'(lvl);
    @(negedge clk); cfg_we_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(!irq_32_o && !irq_min_o && !rd_valid_o, "R1", "outputs in reset", int'(irq_32_o | irq_min_o | rd_valid_o), 0);
    rst_ni = 1'b1;
    started = 1;
    enable_i = 1'b1;
    do_read("R1");
    // R6: program levels
    do_cfg(1'b0, 3);
    do_cfg(1'b1, 9);
    // R2/R7: normal ratio, reads at assorted phases
    for (int i = 0; i < 12; i++) begin
      repeat (23 + i) @(negedge clk);
      do_read("R2 R7");
    end
    repeat (400) @(negedge clk);
    do_read("R2 R4");
    // R8: disabled stretch
    enable_i = 1'b0;
    do_read("R8");
    repeat (60) @(negedge clk);
    do_read("R8");
    enable_i = 1'b1;
    do_read("R8 frozen");
    // R6: new level seen on the next pulse
    do_cfg(1'b0, 12);
    test_mode_i = 1'b1;
    repeat (160) @(negedge clk);
    do_read("R2 R6");
    // R5: level 0 suppresses the 32 ms request
    do_cfg(1'b0, 0);
    base = n32;
    repeat (200) @(negedge clk);
    chk(n32 == base, "R5", "pulses at level 0", n32 - base, 0);
    do_cfg(1'b0, 5);
    // R3/R4: run through the minute wrap
    while (nmin == 0) begin
      repeat (997) @(negedge clk);
      do_read("R3 R7");
    end
    repeat (50) @(negedge clk);
    for (int i = 0; i < 6; i++) do_read("R3 R7");
    repeat (5) @(negedge clk);
    chk(nmin == 1, "R3", "minute requests", nmin, 1);
    chk(nboth == 1, "R4", "paired requests at wrap", nboth, 1);
    chk(exp_q.size() == 0, "R7", "reads unanswered", exp_q.size(), 0);
    finish_run();
  end
endmodule